// File: doc/BRIEF.md
# Set-Clear Interrupt Status Unit

This unit gathers thirteen single-cycle event pulses into sticky status flags and raises one interrupt line whenever a flagged source is also enabled. Software never writes the enable mask as a whole. One register address turns mask bits on for every 1 in the written word. A second address turns mask bits off for every 1. A third address returns the current mask. Because of this, two agents can change different mask bits without a read-modify-write race.

Status flags are write-one-to-clear. A flag is recorded whether or not its source is enabled, so software can poll sources that it has not enabled for interrupts. When an event arrives in the same cycle that software clears its flag, the event wins, so no pulse is lost. The register port is a plain write strobe with an address and a combinational read. Reads have no side effects.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the mask is all zeros, the status is all zeros and `irqOut` is 0.
- R2: A write to address 0 sets each mask bit whose written bit is 1, and leaves every mask bit whose written bit is 0 unchanged.
- R3: A write to address 1 clears each mask bit whose written bit is 1, and leaves the other mask bits unchanged.
- R4: Address 2 reads the current mask. A write to address 2 changes neither the mask nor the status. Addresses 0 and 1 read as zero.
- R5: Address 3 reads the status. A status bit, once set, stays set until it is cleared by a write, even after its event input returns low.
- R6: A write to address 3 clears each status bit whose written bit is 1. A written 0 leaves its status bit unchanged.
- R7: A pulse on `evtIn[k]` sets status bit k on the next clock edge, regardless of mask bit k.
- R8: If `evtIn[k]` pulses in the same cycle as a write to address 3 with bit k set, status bit k is 1 afterwards.
- R9: `irqOut` is 1 exactly when at least one bit position has both its status bit and its mask bit set.
- R10: The source-to-bit map is fixed, and source k drives status bit k. Bits 0 to 12 are:
  - bit 0: receive trigger
  - bit 1: receive empty
  - bit 2: receive full
  - bit 3: transmit empty
  - bit 4: transmit full
  - bit 5: receive overflow
  - bit 6: framing error
  - bit 7: parity error
  - bit 8: receive timeout
  - bit 9: modem-status change
  - bit 10: transmit trigger
  - bit 11: transmit nearly full
  - bit 12: transmit overflow
- R11: Writing 0x1FFF to address 1 and then 0x1FFF to address 3, with no new events, leaves the mask at 0, the status at 0 and `irqOut` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both reads and writes |
| wrData | input | 13 | Write data |
| rdData | output | 13 | Combinational read data for `addr` |
| evtIn | input | 13 | Single-cycle event pulses, one per source |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is R8: an event pulse and a clearing write to the same bit must land on the same clock edge. The bench reaches it by driving `evtIn` and the address-3 write together, within one cycle of its driver task. It then reads the status back to confirm the bit survived.

The other delicate case is a write to the mask read address, which must have no effect. This is checked by reading the mask back immediately after such a write.

// File: rtl/isu_pkg.sv
`timescale 1ns/1ps
package isu_pkg;
  localparam int NUM_SRC = 13;
  localparam int ADDR_W  = 2;

  // Source bit positions; the order is part of the register contract.
  localparam int SRC_RX_TRIG    = 0;
  localparam int SRC_RX_EMPTY   = 1;
  localparam int SRC_RX_FULL    = 2;
  localparam int SRC_TX_EMPTY   = 3;
  localparam int SRC_TX_FULL    = 4;
  localparam int SRC_RX_OVFL    = 5;
  localparam int SRC_FRAME_ERR  = 6;
  localparam int SRC_PARITY_ERR = 7;
  localparam int SRC_RX_TMO     = 8;
  localparam int SRC_MODEM_CHG  = 9;
  localparam int SRC_TX_TRIG    = 10;
  localparam int SRC_TX_NFULL   = 11;
  localparam int SRC_TX_OVFL    = 12;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_MASK   = 2'd2,
    REG_STATUS = 2'd3
  } regAddrT;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STATUS = 2'd2
  } rdSelT;

  typedef struct packed {
    logic  maskSet;
    logic  maskClr;
    logic  statClr;
    rdSelT rdSel;
  } ctrlStrobeT;
endpackage

// File: rtl/isu_ctrl.sv
`timescale 1ns/1ps
module isu_ctrl
  import isu_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobeT        strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_ZERO;
    case (regAddrT'(addr))
      REG_EN_SET: strb.maskSet = wrEn;
      REG_EN_CLR: strb.maskClr = wrEn;
      REG_MASK:   strb.rdSel   = SEL_MASK;
      REG_STATUS: begin
        strb.statClr = wrEn;
        strb.rdSel   = SEL_STATUS;
      end
      default: strb.rdSel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/isu_datapath.sv
`timescale 1ns/1ps
module isu_datapath
  import isu_pkg::*;
#(
  parameter int NumSrc = NUM_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [NumSrc-1:0] wrData,
  input  logic [NumSrc-1:0] evtIn,
  output logic [NumSrc-1:0] maskQ,
  output logic [NumSrc-1:0] statusQ,
  output logic [NumSrc-1:0] rdData,
  output logic              irqOut
);
  logic [NumSrc-1:0] setVec, clrVec, w1cVec;
  logic [NumSrc-1:0] maskNext, statNext;

  assign setVec   = strb.maskSet ? wrData : '0;
  assign clrVec   = strb.maskClr ? wrData : '0;
  assign w1cVec   = strb.statClr ? wrData : '0;
  assign maskNext = (maskQ | setVec) & ~clrVec;

  // One sticky cell per source; the event has priority over the clear.
  for (genvar i = 0; i < NumSrc; i++) begin : g_stat
    assign statNext[i] = evtIn[i] | (statusQ[i] & ~w1cVec[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      maskQ   <= maskNext;
      statusQ <= statNext;
    end
  end

  assign irqOut = |(statusQ & maskQ);

  always_comb begin
    case (strb.rdSel)
      SEL_MASK:   rdData = maskQ;
      SEL_STATUS: rdData = statusQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int NumSrc = NUM_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NumSrc-1:0] wrData,
  output logic [NumSrc-1:0] rdData,
  input  logic [NumSrc-1:0] evtIn,
  output logic              irqOut
);
  ctrlStrobeT        strb;
  logic [NumSrc-1:0] maskQ;
  logic [NumSrc-1:0] statusQ;

  isu_ctrl ctrl_i (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  isu_datapath #(.NumSrc(NumSrc)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .evtIn   (evtIn),
    .maskQ   (maskQ),
    .statusQ (statusQ),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/isu_checker.sv
`timescale 1ns/1ps
module isu_checker
  import isu_pkg::*;
#(
  parameter int NumSrc = NUM_SRC
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NumSrc-1:0] wrData,
  input logic [NumSrc-1:0] evtIn,
  input logic [NumSrc-1:0] maskQ,
  input logic [NumSrc-1:0] statusQ,
  input logic              irqOut
);
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_EN_SET) |=> ((maskQ & $past(wrData)) == $past(wrData)));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_EN_CLR) |=> ((maskQ & $past(wrData)) == '0));

  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == REG_EN_SET || addr == REG_EN_CLR)) |=> $stable(maskQ));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == REG_STATUS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R7 and R8: every pulsed source is flagged on the next edge.
  a_r7_event_captured: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((statusQ & $past(evtIn)) == $past(evtIn)));

  a_r9_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);
endmodule

bind irq_status_unit isu_checker #(.NumSrc(NumSrc)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .evtIn   (evtIn),
  .maskQ   (maskQ),
  .statusQ (statusQ),
  .irqOut  (irqOut)
);

// File: tb/irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module irq_status_unit_tb_top;
  import isu_pkg::*;
  localparam int N = NUM_SRC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] evtIn = '0;
  logic [N-1:0] rdData;
  logic irqOut;

  always #2.5 clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .irqOut(irqOut)
  );

  typedef struct {
    logic [N-1:0] data;
    logic         irq;
    string        tag;
  } expT;

  expT sbQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  event sampleEv;
  logic [N-1:0] mMask = '0;
  logic [N-1:0] mStat = '0;

  task automatic doCycle(input logic we, input logic [ADDR_W-1:0] a,
                         input logic [N-1:0] d, input logic [N-1:0] ev);
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; evtIn = ev;
    if (we && a == REG_EN_SET) mMask = mMask | d;
    if (we && a == REG_EN_CLR) mMask = mMask & ~d;
    if (we && a == REG_STATUS) mStat = mStat & ~d;
    mStat = mStat | ev;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtIn = '0;
  endtask

  task automatic expectRead(input logic [ADDR_W-1:0] a, input logic [N-1:0] expData,
                            input string tag);
    expT it;
    wrEn = 1'b0; addr = a;
    #1;
    it.data = expData;
    it.irq  = |(mMask & mStat);
    it.tag  = tag;
    sbQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  initial begin
    expT it;
    forever begin
      @(sampleEv);
      it = sbQ.pop_front();
      checks++;
      if (rdData !== it.data || irqOut !== it.irq) begin
        errors++;
        $display("FAIL %s: rdData=%h irqOut=%b expected rdData=%h irqOut=%b",
                 it.tag, rdData, irqOut, it.data, it.irq);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectRead(REG_MASK, '0, "R1 mask after reset");
    expectRead(REG_STATUS, '0, "R1 status after reset");
    // R2 set with ones, zeros untouched
    doCycle(1'b1, REG_EN_SET, 13'h0005, '0);
    expectRead(REG_MASK, 13'h0005, "R2 set 0x005");
    doCycle(1'b1, REG_EN_SET, 13'h0100, '0);
    expectRead(REG_MASK, 13'h0105, "R2 zeros keep bits");
    // R3 clear
    doCycle(1'b1, REG_EN_CLR, 13'h0004, '0);
    expectRead(REG_MASK, 13'h0101, "R3 clear bit 2");
    // R4 write to mask address ignored, set/clear addresses read zero
    doCycle(1'b1, REG_MASK, 13'h1FFF, '0);
    expectRead(REG_MASK, 13'h0101, "R4 mask write ignored");
    expectRead(REG_STATUS, '0, "R4 status untouched by mask write");
    expectRead(REG_EN_SET, '0, "R4 set address reads zero");
    expectRead(REG_EN_CLR, '0, "R4 clear address reads zero");
    // R7 event on disabled source is recorded, R9 no irq
    doCycle(1'b0, REG_MASK, '0, 13'h0008);
    expectRead(REG_STATUS, 13'h0008, "R7 disabled source recorded, R9 irq low");
    // R5 sticky over idle cycles
    doCycle(1'b0, REG_MASK, '0, '0);
    doCycle(1'b0, REG_MASK, '0, '0);
    expectRead(REG_STATUS, 13'h0008, "R5 status sticky");
    // R9 enabling raises irq
    doCycle(1'b1, REG_EN_SET, 13'h0008, '0);
    expectRead(REG_STATUS, 13'h0008, "R9 irq high once enabled");
    // R6 writing zero keeps, writing one clears
    doCycle(1'b1, REG_STATUS, 13'h0000, '0);
    expectRead(REG_STATUS, 13'h0008, "R6 zero write keeps bit");
    doCycle(1'b1, REG_STATUS, 13'h0008, '0);
    expectRead(REG_STATUS, 13'h0000, "R6 one write clears, R9 irq low");
    // R8 event beats same-cycle clear
    doCycle(1'b1, REG_EN_SET, 13'h0020, '0);
    doCycle(1'b0, REG_MASK, '0, 13'h0020);
    doCycle(1'b1, REG_STATUS, 13'h0020, 13'h0020);
    expectRead(REG_STATUS, 13'h0020, "R8 event wins over clear");
    // R10 each source lands on its own bit
    doCycle(1'b1, REG_EN_SET, 13'h1FFF, '0);
    for (int b = 0; b < N; b++) begin
      doCycle(1'b1, REG_STATUS, 13'h1FFF, '0);
      doCycle(1'b0, REG_MASK, '0, N'(1) << b);
      expectRead(REG_STATUS, N'(1) << b, $sformatf("R10 source bit %0d", b));
    end
    // R11 quiet sequence
    doCycle(1'b0, REG_MASK, '0, 13'h1FFF);
    doCycle(1'b1, REG_EN_CLR, 13'h1FFF, '0);
    doCycle(1'b1, REG_STATUS, 13'h1FFF, '0);
    expectRead(REG_MASK, '0, "R11 mask quiet");
    expectRead(REG_STATUS, '0, "R11 status quiet, irq low");
    done = 1'b1;
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..R11 sequence incomplete): done=0 expected done=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule